// File: doc/BRIEF.md
# SCL Bit-Rate Generator

This block turns the system clock into the bit timing of an I2C master. A packed 7-bit rate word holds a linear factor M in bits [6:3] and a power-of-two exponent N in bits [2:0]. The clock passes through two divider stages in series. The first stage is a power-of-two prescaler. The second stage divides by M+1. Each pulse out of the second stage is one timing tick, and ten ticks make one SCL period. The first five ticks of a period form the low phase and the last five form the high phase. The bus engine uses the tick, the phase level and the end-of-period pulse to place its SDA and SCL changes.

A compile-time parameter selects how the prescaler counts. With `DOUBLE_STAGE=1` one SCL period lasts 10·(M+1)·2^(N+1) clocks. With `DOUBLE_STAGE=0` it lasts 10·(M+1)·2^N clocks. Software changes the rate with a single-cycle write strobe. The new value is buffered and only replaces the rate in use at an SCL period boundary, so no phase is ever cut short. While the controller enable is low, the generator is held cleared. A synchronous soft reset restores the rate word to its power-on value.

Top module: `scl_rate_gen`

## Requirements
- R1: After `rst_n` is released, the rate word in use is 0x44 (M=8, N=4). With `DOUBLE_STAGE=1` a full SCL period is then 2880 clocks, and with `DOUBLE_STAGE=0` it is 1440 clocks.
- R2: The rate word is decoded as M = bits [6:3] and N = bits [2:0]. With `DOUBLE_STAGE=1` a full period is 10·(M+1)·2^(N+1) clocks.
- R3: `scl_tick` pulses once every (M+1)·2^(N+DOUBLE_STAGE) clocks, and a full period contains exactly 10 ticks.
- R4: `scl_high` is 0 for the first 5·P clocks of each period and 1 for the last 5·P clocks, where P is the tick spacing. It changes only on a cycle that follows a tick or a hold.
- R5: `period_end` pulses for one cycle at the last tick of each period. Consecutive pulses are one full period apart.
- R6: A rate write made while the generator runs does not change the period in progress. The written value applies from the next period on.
- R7: While `enable` is 0, `scl_tick`, `scl_high` and `period_end` stay 0. Rate writes made in that time apply at once. After `enable` rises, the first `period_end` comes 10·P−1 clock cycles after the cycle in which `enable` was first sampled high.
- R8: A one-cycle `soft_rst` pulse clears the sequence and restores the rate word in use to 0x44. The next period starts from zero at the 0x44 rate.
- R9: With `DOUBLE_STAGE=0` the prescaler divides by 2^N, so rate word 0x00 gives a 10-clock period with a tick on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; the generator is held cleared while it is low |
| soft_rst | input | 1 | Synchronous soft reset, one-cycle pulse |
| baud_we | input | 1 | Rate word write strobe |
| baud_wdata | input | 7 | Rate word: M in [6:3], N in [2:0] |
| scl_tick | output | 1 | One-cycle timing tick, ten per SCL period |
| scl_high | output | 1 | SCL phase level: 0 in the low half, 1 in the high half |
| period_end | output | 1 | One-cycle pulse on the last tick of a period |

## Verification
The assertions assume that `soft_rst` and `baud_we` are single-cycle strobes aligned to the clock. They also assume that `enable` changes only between clock edges, so the hold condition seen by the checker matches the one that cleared the counters. The stimulus drives every input at the falling edge. It writes rate words either while the generator is disabled or in the cycle after a period boundary, never on the boundary cycle itself. With that restriction, the period that the bench expects after each write is fixed by R6 and R7.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  // Terminal count of the power-of-two stage: 2^(n+extra) - 1
  function automatic int unsigned pow_limit(int unsigned n, bit extra);
    return (32'd1 << (n + 32'(extra))) - 32'd1;
  endfunction

  // Clocks between ticks for a given M and N
  function automatic int unsigned tick_spacing(int unsigned m, int unsigned n, bit extra);
    return (m + 32'd1) * (pow_limit(n, extra) + 32'd1);
  endfunction

endpackage

// File: rtl/scl_pow2_stage.sv
module scl_pow2_stage #(
  parameter int N_W          = 3,
  parameter int DOUBLE_STAGE = 1,
  parameter int POW_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [N_W-1:0]   n_sel,
  output logic             stage_done
);
  import scl_rate_pkg::*;

  logic [POW_W-1:0] cnt_q;
  logic [POW_W-1:0] limit;

  generate
    if (DOUBLE_STAGE != 0) begin : g_double
      assign limit = POW_W'(pow_limit(32'(n_sel), 1'b1));
    end else begin : g_single
      assign limit = POW_W'(pow_limit(32'(n_sel), 1'b0));
    end
  endgenerate

  assign stage_done = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear)      cnt_q <= '0;
    else if (stage_done) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_lin_stage.sv
module scl_lin_stage #(
  parameter int M_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           step,
  input  logic [M_W-1:0] m_sel,
  output logic           stage_done
);
  logic [M_W-1:0] cnt_q;
  logic           at_last;

  assign at_last    = (cnt_q == m_sel);
  assign stage_done = step && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (step)   cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int HALF_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic scl_high,
  output logic period_end
);
  import scl_rate_pkg::*;

  localparam int PERIOD_TICKS = 2 * HALF_TICKS;
  localparam int SEQ_W        = $clog2(PERIOD_TICKS);
  localparam logic [SEQ_W-1:0] LAST = SEQ_W'(PERIOD_TICKS - 1);
  localparam logic [SEQ_W-1:0] HALF = SEQ_W'(HALF_TICKS);

  logic [SEQ_W-1:0] seq_q;
  scl_phase_e       phase;

  assign phase      = (seq_q >= HALF) ? PH_HIGH : PH_LOW;
  assign scl_high   = (phase == PH_HIGH);
  assign period_end = tick && (seq_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seq_q <= '0;
    else if (clear) seq_q <= '0;
    else if (tick)  seq_q <= (seq_q == LAST) ? '0 : seq_q + 1'b1;
  end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int                    M_W          = 4,
  parameter int                    N_W          = 3,
  parameter int                    DOUBLE_STAGE = 1,
  parameter int                    HALF_TICKS   = 5,
  parameter logic [M_W+N_W-1:0]    BAUD_RST     = 7'h44
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               soft_rst,
  input  logic               baud_we,
  input  logic [M_W+N_W-1:0] baud_wdata,
  output logic               scl_tick,
  output logic               scl_high,
  output logic               period_end
);
  localparam int BAUD_W = M_W + N_W;
  localparam int POW_W  = (1 << N_W) - 1 + DOUBLE_STAGE;

  logic [BAUD_W-1:0] baud_buf_q;
  logic [BAUD_W-1:0] baud_act_q;
  logic [BAUD_W-1:0] baud_next;
  logic              hold_w;
  logic              pow_done_w;
  logic              lin_step_w;
  logic              lin_done_w;

  // Named internal events used by the checker
  assign hold_w     = !enable || soft_rst;
  assign baud_next  = baud_we ? baud_wdata : baud_buf_q;
  assign lin_step_w = !hold_w && pow_done_w;
  assign scl_tick   = lin_done_w;

  // Buffered rate word written by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        baud_buf_q <= BAUD_RST;
    else if (soft_rst) baud_buf_q <= BAUD_RST;
    else if (baud_we)  baud_buf_q <= baud_wdata;
  end

  // Rate word in use: follows the buffer while held, else only at a boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       baud_act_q <= BAUD_RST;
    else if (soft_rst)                baud_act_q <= BAUD_RST;
    else if (!enable || period_end)   baud_act_q <= baud_next;
  end

  scl_pow2_stage #(
    .N_W(N_W), .DOUBLE_STAGE(DOUBLE_STAGE), .POW_W(POW_W)
  ) u_pow (
    .clk(clk), .rst_n(rst_n), .clear(hold_w),
    .n_sel(baud_act_q[N_W-1:0]), .stage_done(pow_done_w)
  );

  scl_lin_stage #(.M_W(M_W)) u_lin (
    .clk(clk), .rst_n(rst_n), .clear(hold_w), .step(lin_step_w),
    .m_sel(baud_act_q[BAUD_W-1:N_W]), .stage_done(lin_done_w)
  );

  scl_phase_seq #(.HALF_TICKS(HALF_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear(hold_w), .tick(lin_done_w),
    .scl_high(scl_high), .period_end(period_end)
  );
endmodule

// File: rtl/scl_rate_chk.sv
module scl_rate_chk #(
  parameter int              BAUD_W   = 7,
  parameter logic [BAUD_W-1:0] BAUD_RST = 7'h44
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic              soft_rst,
  input logic              tick,
  input logic              scl_high,
  input logic              period_end,
  input logic [BAUD_W-1:0] active_baud
);
  p_phase_moves_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hold) |=> $stable(scl_high));

  p_period_starts_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !hold) |=> !scl_high);

  p_rate_fixed_in_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !hold) |=> $stable(active_baud));

  p_hold_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !scl_high);

  p_soft_reset_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (active_baud == BAUD_RST));

  p_end_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);
endmodule

bind scl_rate_gen scl_rate_chk #(.BAUD_W(BAUD_W), .BAUD_RST(BAUD_RST)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold_w), .soft_rst(soft_rst),
  .tick(scl_tick), .scl_high(scl_high), .period_end(period_end),
  .active_baud(baud_act_q)
);

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       soft_rst = 1'b0;
  logic       baud_we = 1'b0;
  logic [6:0] baud_wdata = 7'h00;
  logic       tick0, high0, end0;
  logic       tick1, high1, end1;
  int         n_checks = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  scl_rate_gen #(.DOUBLE_STAGE(1)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
    .baud_we(baud_we), .baud_wdata(baud_wdata),
    .scl_tick(tick0), .scl_high(high0), .period_end(end0));

  scl_rate_gen #(.DOUBLE_STAGE(0)) u1 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
    .baud_we(baud_we), .baud_wdata(baud_wdata),
    .scl_tick(tick1), .scl_high(high1), .period_end(end1));

  // Independent restatement: clocks in one SCL period
  function automatic int exp_period(input logic [6:0] b, input int dbl);
    int m = int'(b[6:3]);
    int n = int'(b[2:0]);
    return 10 * (m + 1) * (1 << (n + dbl));
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Counts falling edges up to and including the next period_end of one instance
  task automatic wait_end(input bit which, output int cycles, output int highs, output int ticks);
    cycles = 0; highs = 0; ticks = 0;
    forever begin
      @(negedge clk);
      cycles++;
      if (which ? high1 : high0) highs++;
      if (which ? tick1 : tick0) ticks++;
      if (which ? end1 : end0) break;
    end
  endtask

  task automatic write_baud(input logic [6:0] b);
    baud_wdata = b; baud_we = 1'b1;
    @(negedge clk);
    baud_we = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R7", int'(high0 | tick0 | end0 | high1 | tick1 | end1), 0, "outputs while disabled");
  endtask

  task automatic t_reset_rate();
    int c, h, t;
    enable = 1'b1;
    wait_end(1'b0, c, h, t);
    check("R1", c, exp_period(7'h44, 1) - 1, "first period after reset u0");
    wait_end(1'b0, c, h, t);
    check("R1", c, 2880, "full period at reset rate u0");
    check("R4", h, 1440, "high clocks at reset rate");
    check("R3", t, 10, "ticks per period");
    wait_end(1'b1, c, h, t);
    wait_end(1'b1, c, h, t);
    check("R9", c, 1440, "full period at reset rate u1");
  endtask

  task automatic t_rate(input logic [6:0] b);
    int c, h, t;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    write_baud(b);
    enable = 1'b1;
    wait_end(1'b0, c, h, t);
    check("R7", c, exp_period(b, 1) - 1, "first period after enable");
    wait_end(1'b0, c, h, t);
    check("R2", c, exp_period(b, 1), "full period");
    check("R4", h, exp_period(b, 1) / 2, "high half");
    check("R3", t, 10, "ticks per period");
    wait_end(1'b1, c, h, t);
    wait_end(1'b1, c, h, t);
    check("R9", c, exp_period(b, 0), "full period single-stage variant");
    check("R5", t, 10, "ticks between period ends u1");
  endtask

  task automatic t_boundary();
    int c, h, t;
    wait_end(1'b0, c, h, t);           // boundary of a 0x09 period
    @(negedge clk);                    // one cycle into the next period
    write_baud(7'h13);                 // consumes a second cycle
    wait_end(1'b0, c, h, t);
    check("R6", c, exp_period(7'h09, 1) - 2, "period in progress keeps old rate");
    wait_end(1'b0, c, h, t);
    check("R6", c, exp_period(7'h13, 1), "next period uses new rate");
    check("R5", t, 10, "ticks between period ends u0");
  endtask

  task automatic t_disable_mid();
    int c, h, t, seen;
    while (!high0) @(negedge clk);
    enable = 1'b0;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (high0 || tick0 || end0) seen++;
    end
    check("R7", seen, 0, "outputs active while disabled mid-period");
    enable = 1'b1;
    wait_end(1'b0, c, h, t);
    check("R7", c, exp_period(7'h13, 1) - 1, "restart after mid-period disable");
  endtask

  task automatic t_soft_reset();
    int c, h, t;
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check("R8", int'(high0 | high1), 0, "phase cleared by soft reset");
    wait_end(1'b1, c, h, t);
    check("R8", c, exp_period(7'h44, 0) - 1, "first period after soft reset u1");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_reset_rate();
    t_rate(7'h00);
    t_rate(7'h13);
    t_rate(7'h0F);
    t_rate(7'h09);
    t_boundary();
    t_disable_mid();
    t_soft_reset();
    report();
  end
endmodule